// File: doc/BRIEF.md
# Compare and Branch Condition Unit

This block keeps the 2-bit condition code of a small processor and answers the branch question. An operation-class select tells it what the current cycle is doing. A compare orders two operands and writes greater, equal or less into the code. A load or arithmetic step writes the sign and zero state of its result into the code. A branch, call or return tests the stored code against the instruction's condition field. Any other cycle leaves the code alone.

The code never holds 11. A condition field of 11 therefore means "always taken". The test can be taken on equality with the field or on inequality with it. Compares order their operands as two's-complement values unless the logical-compare bit is set, in which case they use plain unsigned order. All outputs are registered, so results appear one clock after the inputs are presented.

Top module: `cond_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `cc_q`=00, `cc_wr`=0 and `br_taken`=0.
- R2: With `op_class`=01 (compare) and `cmp_logical`=0, `cc_q` becomes 01 if `opnd_a` > `opnd_b` as signed values, 00 if they are equal and 10 if `opnd_a` is less, one cycle later.
- R3: With `op_class`=01 and `cmp_logical`=1, the same encoding is produced using unsigned ordering.
- R4: With `op_class`=10 (result), `cc_q` becomes 00 if `opnd_a` is zero, 10 if its top bit is set, and 01 otherwise, one cycle later.
- R5: `cc_q` never holds 11.
- R6: `cc_wr` is high in the cycle after a compare or result operation, and low after any other class.
- R7: With `op_class`=00 (idle) or 11 (branch test), `cc_q` keeps its value.
- R8: With `op_class`=11 and `cond_sel`=11, `br_taken` is 1 in the next cycle whatever the code and `cond_ne`.
- R9: With `op_class`=11, `cond_ne`=0 and `cond_sel` not 11, `br_taken` is 1 in the next cycle exactly when `cc_q` equals `cond_sel`.
- R10: With `op_class`=11, `cond_ne`=1 and `cond_sel` not 11, `br_taken` is 1 in the next cycle exactly when `cc_q` differs from `cond_sel`.
- R11: `br_taken` is 0 in the cycle after any class other than branch test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 2 | 00 idle, 01 compare, 10 result, 11 branch test |
| opnd_a | input | DATA_W | First compare operand, or the result to classify |
| opnd_b | input | DATA_W | Second compare operand |
| cmp_logical | input | 1 | 1 selects unsigned compare order, 0 selects signed |
| cond_sel | input | 2 | Branch condition field; 11 means always |
| cond_ne | input | 1 | 1 takes the branch when the code differs from the field |
| cc_q | output | 2 | Stored condition code |
| cc_wr | output | 1 | Pulses when the code was written |
| br_taken | output | 1 | Branch decision for the previous branch-test cycle |

## Verification
The assertions expect `op_class` and the operand and condition inputs to be known values at every clock edge after reset. They do not require the inputs to hold steady between operations. The stimulus drives every input on the falling edge and returns `op_class` to idle between scenarios. This keeps the inputs defined at each rising edge. The branch checks first set each legal code with a result operation, then sweep every field and both senses.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef enum logic [1:0] {
    OPC_IDLE   = 2'b00,
    OPC_CMP    = 2'b01,
    OPC_RESULT = 2'b10,
    OPC_BRTEST = 2'b11
  } op_class_e;

  localparam logic [1:0] CODE_EQ  = 2'b00;
  localparam logic [1:0] CODE_GT  = 2'b01;
  localparam logic [1:0] CODE_LT  = 2'b10;
  localparam logic [1:0] COND_ANY = 2'b11;
endpackage

// File: rtl/cbu_compare.sv
module cbu_compare #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic              logical,
  output logic [1:0]        code
);
  import cbu_pkg::*;
  localparam int MSB = DATA_W - 1;

  // Flipping the top bit maps two's-complement order onto unsigned order,
  // so one magnitude comparator serves both modes.
  logic [DATA_W-1:0] lhs_k, rhs_k;
  always_comb begin
    lhs_k      = lhs;
    rhs_k      = rhs;
    lhs_k[MSB] = lhs[MSB] ^ ~logical;
    rhs_k[MSB] = rhs[MSB] ^ ~logical;
    if (lhs_k == rhs_k)     code = CODE_EQ;
    else if (lhs_k > rhs_k) code = CODE_GT;
    else                    code = CODE_LT;
  end
endmodule

// File: rtl/cbu_classify.sv
module cbu_classify #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] value,
  output logic [1:0]        code
);
  import cbu_pkg::*;
  always_comb begin
    if (value == '0)          code = CODE_EQ;
    else if (value[DATA_W-1]) code = CODE_LT;
    else                      code = CODE_GT;
  end
endmodule

// File: rtl/cbu_cond_test.sv
module cbu_cond_test (
  input  logic [1:0] code,
  input  logic [1:0] field,
  input  logic       invert,
  output logic       take
);
  import cbu_pkg::*;
  logic match;
  always_comb begin
    match = (code == field);
    if (field == COND_ANY) take = 1'b1;
    else                   take = match ^ invert;
  end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_class,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              cmp_logical,
  input  logic [1:0]        cond_sel,
  input  logic              cond_ne,
  output logic [1:0]        cc_q,
  output logic              cc_wr,
  output logic              br_taken
);
  import cbu_pkg::*;

  op_class_e  opc;
  logic [1:0] cmp_code, res_code;
  logic       take_now;

  assign opc = op_class_e'(op_class);

  cbu_compare #(.DATA_W(DATA_W)) u_cmp (
    .lhs(opnd_a), .rhs(opnd_b), .logical(cmp_logical), .code(cmp_code)
  );

  cbu_classify #(.DATA_W(DATA_W)) u_cls (
    .value(opnd_a), .code(res_code)
  );

  cbu_cond_test u_test (
    .code(cc_q), .field(cond_sel), .invert(cond_ne), .take(take_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q     <= CODE_EQ;
      cc_wr    <= 1'b0;
      br_taken <= 1'b0;
    end else begin
      cc_wr    <= 1'b0;
      br_taken <= 1'b0;
      unique case (opc)
        OPC_CMP: begin
          cc_q  <= cmp_code;
          cc_wr <= 1'b1;
        end
        OPC_RESULT: begin
          cc_q  <= res_code;
          cc_wr <= 1'b1;
        end
        OPC_BRTEST: br_taken <= take_now;
        default: ;
      endcase
    end
  end

  // Code register guards
  assert_code_legal_R5: assert property (@(posedge clk) disable iff (rst)
    cc_q != 2'b11);
  assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b00 || op_class == 2'b11) |=> $stable(cc_q));
  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b01 || op_class == 2'b10) |=> cc_wr);
  assert_wr_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b00 || op_class == 2'b11) |=> !cc_wr);
  assert_cmp_equal_R2: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b01 && opnd_a == opnd_b) |=> cc_q == 2'b00);
  assert_zero_result_R4: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b10 && opnd_a == '0) |=> cc_q == 2'b00);

  // Branch decision guards
  assert_always_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b11 && cond_sel == 2'b11) |=> br_taken);
  assert_eq_sense_R9: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'b11 && cond_sel != 2'b11 && !cond_ne)
      |=> (br_taken == ($past(cc_q) == $past(cond_sel))));
  assert_no_branch_R11: assert property (@(posedge clk) disable iff (rst)
    (op_class != 2'b11) |=> !br_taken);
endmodule

// File: tb/tb_cond_branch_unit.sv
module tb_cond_branch_unit;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        op_class;
  logic [DATA_W-1:0] opnd_a, opnd_b;
  logic              cmp_logical, cond_ne;
  logic [1:0]        cond_sel;
  logic [1:0]        cc_q;
  logic              cc_wr, br_taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cond_branch_unit #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .op_class(op_class), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .cmp_logical(cmp_logical), .cond_sel(cond_sel),
    .cond_ne(cond_ne), .cc_q(cc_q), .cc_wr(cc_wr), .br_taken(br_taken)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_cmp(input logic [7:0] a, input logic [7:0] b,
                                           input logic uns);
    if (uns) return (a == b) ? 2'b00 : (a > b) ? 2'b01 : 2'b10;
    return ($signed(a) == $signed(b)) ? 2'b00 :
           ($signed(a) > $signed(b)) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] model_res(input logic [7:0] a);
    if (a == 8'h00) return 2'b00;
    if (a[7])       return 2'b10;
    return 2'b01;
  endfunction

  // Drive one operation on the falling edge, then sample after the next rise.
  task automatic step(input logic [1:0] opc, input logic [7:0] a, input logic [7:0] b,
                      input logic uns, input logic [1:0] fld, input logic ne);
    @(negedge clk);
    op_class = opc; opnd_a = a; opnd_b = b;
    cmp_logical = uns; cond_sel = fld; cond_ne = ne;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    step(2'b00, 8'h00, 8'h00, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    op_class = 2'b01; opnd_a = 8'h05; opnd_b = 8'h01;
    @(posedge clk); #1;
    chk("R1 cc", cc_q, 0); chk("R1 wr", cc_wr, 0); chk("R1 taken", br_taken, 0);
    @(negedge clk); rst = 1'b0; op_class = 2'b00;
  endtask

  task automatic t_cmp_signed();
    logic [7:0] av [6] = '{8'h05, 8'h03, 8'h7f, 8'h80, 8'hff, 8'h40};
    logic [7:0] bv [6] = '{8'h03, 8'h05, 8'h80, 8'h7f, 8'hff, 8'h40};
    for (int i = 0; i < 6; i++) begin
      step(2'b01, av[i], bv[i], 1'b0, 2'b00, 1'b0);
      chk("R2 signed cmp", cc_q, model_cmp(av[i], bv[i], 1'b0));
      chk("R6 wr after cmp", cc_wr, 1);
      chk("R11 no branch", br_taken, 0);
    end
  endtask

  task automatic t_cmp_unsigned();
    logic [7:0] av [4] = '{8'h80, 8'h7f, 8'hff, 8'h01};
    logic [7:0] bv [4] = '{8'h7f, 8'h80, 8'h00, 8'h01};
    for (int i = 0; i < 4; i++) begin
      step(2'b01, av[i], bv[i], 1'b1, 2'b00, 1'b0);
      chk("R3 unsigned cmp", cc_q, model_cmp(av[i], bv[i], 1'b1));
    end
  endtask

  task automatic t_result();
    logic [7:0] av [5] = '{8'h00, 8'h01, 8'h7f, 8'h80, 8'hfe};
    for (int i = 0; i < 5; i++) begin
      step(2'b10, av[i], 8'h55, 1'b0, 2'b00, 1'b0);
      chk("R4 result code", cc_q, model_res(av[i]));
      chk("R6 wr after result", cc_wr, 1);
      chk("R5 legal code", (cc_q != 2'b11), 1);
    end
  endtask

  task automatic t_hold();
    step(2'b10, 8'h90, 8'h00, 1'b0, 2'b00, 1'b0);
    step(2'b00, 8'h00, 8'h10, 1'b0, 2'b00, 1'b0);
    chk("R7 hold idle", cc_q, 2); chk("R6 wr idle", cc_wr, 0);
    step(2'b11, 8'h00, 8'h00, 1'b1, 2'b01, 1'b0);
    chk("R7 hold branch", cc_q, 2); chk("R6 wr branch", cc_wr, 0);
    idle();
  endtask

  task automatic t_branch_sweep();
    logic [7:0] seed [3] = '{8'h00, 8'h22, 8'hc0};
    for (int c = 0; c < 3; c++) begin
      for (int f = 0; f < 4; f++) begin
        for (int n = 0; n < 2; n++) begin
          step(2'b10, seed[c], 8'h00, 1'b0, 2'b00, 1'b0);
          step(2'b11, 8'h00, 8'h00, 1'b0, 2'(f), 1'(n));
          if (f == 3)      chk("R8 always taken", br_taken, 1);
          else if (n == 0) chk("R9 equal sense", br_taken, int'(c == f));
          else             chk("R10 not-equal sense", br_taken, int'(c != f));
          idle();
          chk("R11 taken clears", br_taken, 0);
        end
      end
    end
  endtask

  initial begin
    rst = 1'b1; op_class = 2'b00; opnd_a = '0; opnd_b = '0;
    cmp_logical = 1'b0; cond_sel = 2'b00; cond_ne = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    t_cmp_signed();
    t_cmp_unsigned();
    t_result();
    t_hold();
    t_branch_sweep();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule